// File: doc/BRIEF.md
# S/PDIF Receiver Enable and Status Controller

This block is the control and status core of a consumer digital audio receiver. Software steps the receiver through three operating levels with a two-bit enable field: off, synchronising (the front end hunts for lock, but no samples are delivered), and receiving (samples and control words are both delivered). The biphase decoder and preamble detector sit outside. They report to this block through single-cycle strobes: input activity, sync achieved, block start, parity error, overrun, frame error, sync error and timeout. They also deliver sample words and control words with valid strobes.

The controller keeps a status word of event and error flags. It also holds a per-event interrupt mask, a write-one-to-clear register for the recoverable events, and one level-sensitive interrupt line. An optional wait-for-activity mode holds the synchroniser back until the selected input toggles, so an unplugged cable causes no sync errors. A coded retry budget lets a chosen number of sync errors pass before one is reported. Frame errors, reported sync errors and timeouts are fatal. They stop the receiver, and only an enable write of 00 releases it.

Software reaches the registers through a simple word-addressed bus. Reads have no wait states and write strobes take effect on the next clock edge.

Top module: `spdif_rx_ctl`

## Requirements
- R1: After reset, every register reads 0, `irq` is 0, the receiver is off, and `sync_run`, `rx_run` and `stopped` are 0.
- R2: The control word (address 0) holds the enable field in bits 1:0.
  - Code 01 raises `sync_run` only.
  - Code 11 raises both `sync_run` and `rx_run`.
  - Codes 00 and 10 leave the receiver idle.
  - Changing the enable field does not alter the recoverable flags in bits 5:0.
- R3: While control bit 2 (wait for activity) is set, the receiver is not armed and ignores all decoder strobes until an activity strobe arrives under code 01 or 11. The memory of activity is lost whenever the code is 00 or 10.
- R4: The status word (address 2) has these bits: 0 data ready, 1 control word ready, 2 parity error, 3 overrun, 4 block start, 5 sync done, 6 frame error, 7 sync error, 8 timeout. Decoder strobes set flags only while the receiver is armed: enabled, activity condition met, and not stopped.
- R5: Control bits 5:4 set the retry code. Codes 0, 1, 2 and 3 let 0, 3, 15 and 63 consecutive sync-error strobes pass unflagged, and the next one sets bit 7. The retry count restarts on sync done, on reporting, and whenever the receiver is not armed.
- R6: Writing ones to bits 5:2 of the clear register (address 3) clears the matching status flags. Other bits of the write have no effect. A flag set in the same cycle as its clear stays set.
- R7: While any of status bits 8:6 is set, `stopped` is high and `sync_run` and `rx_run` are low. Only a control write with enable code 00 clears bits 8:6, and that write wins over a new error in the same cycle.
- R8: The interrupt mask sits at address 1, bits 6:0. `irq` is the OR of status bits 5:0 ANDed with mask bits 5:0, plus status bits 8:6 ANDed with mask bit 6.
- R9: Under code 11 while armed, a sample strobe loads the data word (address 4, low bits) and sets data ready. If data ready is still set and the data word is not being read in that cycle, the strobe also sets overrun. Reading address 4 clears data ready unless a new sample arrives in the same cycle.
- R10: While armed (code 01 or 11), a control-word strobe loads the control-word register (address 5) and sets status bit 1. Reading address 5 clears bit 1.
- R11: Control bits 18:16 select the input: they drive `in_sel` and read back at address 0. Unused addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (drives read side effects) |
| addr | input | 3 | Word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| act_stb | input | 1 | Decoder saw transitions on the selected input |
| syncd_stb | input | 1 | Decoder achieved synchronisation |
| blk_stb | input | 1 | Start of an audio block seen |
| par_stb | input | 1 | Parity error |
| ovr_stb | input | 1 | Overrun reported by the front end |
| ferr_stb | input | 1 | Frame error |
| serr_stb | input | 1 | Synchronisation error |
| tout_stb | input | 1 | Timeout |
| smp_stb | input | 1 | Sample word valid |
| smp_data | input | DATA_W | Sample word |
| cw_stb | input | 1 | Control word valid |
| cw_data | input | CW_W | Control word |
| sync_run | output | 1 | Receiver armed; synchroniser may run |
| rx_run | output | 1 | Armed and in full reception |
| stopped | output | 1 | A fatal error holds the receiver |
| in_sel | output | SEL_W | Selected input |
| irq | output | 1 | Interrupt request |

## Verification
A wrong arming state shows up on `sync_run` and `rx_run` in the same cycle it occurs. It also shows up through flags that fail to set, or set when they should not, on the next strobe, visible one clock later in the status word. A retry counter that is off by one shows a sync-error flag one strobe early or late. A fatal flag that clears too early drops `stopped` and `irq` within one clock of the offending write. The bench therefore compares every output and the read-back word against its own model on every cycle, so any divergence is flagged within one clock of the edge that caused it.

// File: rtl/spdif_rxc_pkg.sv
package spdif_rxc_pkg;

   localparam int BUS_W  = 32;
   localparam int ADDR_W = 3;
   localparam int NFLAG  = 9;
   localparam int MASK_W = 7;
   localparam int CNT_W  = 6;

   // word addresses
   localparam logic [ADDR_W-1:0] A_CTRL  = 3'd0;
   localparam logic [ADDR_W-1:0] A_MASK  = 3'd1;
   localparam logic [ADDR_W-1:0] A_STAT  = 3'd2;
   localparam logic [ADDR_W-1:0] A_CLR   = 3'd3;
   localparam logic [ADDR_W-1:0] A_DATA  = 3'd4;
   localparam logic [ADDR_W-1:0] A_CWORD = 3'd5;

   // control field positions
   localparam int C_WAIT  = 2;
   localparam int C_RETRY = 4;
   localparam int C_SEL   = 16;

   // status flag positions
   localparam int F_DRDY = 0;
   localparam int F_CRDY = 1;
   localparam int F_PAR  = 2;
   localparam int F_OVR  = 3;
   localparam int F_BLK  = 4;
   localparam int F_SYNC = 5;
   localparam int F_FERR = 6;
   localparam int F_SERR = 7;
   localparam int F_TOUT = 8;
   localparam int F_FATAL_LO = 6;

   typedef enum logic [1:0] {
      EN_OFF  = 2'b00,
      EN_SYNC = 2'b01,
      EN_RSVD = 2'b10,
      EN_RECV = 2'b11
   } en_mode_e;

   // tolerated sync errors: 4^code - 1
   function automatic logic [CNT_W-1:0] retry_limit(input logic [1:0] code);
      logic [CNT_W:0] t;
      t = (CNT_W+1)'(1) << (2 * code);
      return CNT_W'(t - (CNT_W+1)'(1));
   endfunction

endpackage

// File: rtl/spdif_rxc_regs.sv
module spdif_rxc_regs
   import spdif_rxc_pkg::*;
#(
   parameter int SEL_W = 3
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 wr_en,
   input  logic [ADDR_W-1:0]    addr,
   input  logic [BUS_W-1:0]     wdata,
   output en_mode_e             mode,
   output logic                 wait_act,
   output logic [1:0]           retry_code,
   output logic [SEL_W-1:0]     in_sel,
   output logic [MASK_W-1:0]    mask,
   output logic                 dis_wr
);

   logic ctrl_wr, mask_wr;
   logic unused_wbits;

   assign ctrl_wr      = wr_en && (addr == A_CTRL);
   assign mask_wr      = wr_en && (addr == A_MASK);
   assign dis_wr       = ctrl_wr && (wdata[1:0] == EN_OFF);
   assign unused_wbits = ^wdata;

   always_ff @(posedge clk) begin
      if (rst) begin
         mode       <= EN_OFF;
         wait_act   <= 1'b0;
         retry_code <= '0;
         in_sel     <= '0;
         mask       <= '0;
      end else begin
         if (ctrl_wr) begin
            mode       <= en_mode_e'(wdata[1:0]);
            wait_act   <= wdata[C_WAIT];
            retry_code <= wdata[C_RETRY +: 2];
            in_sel     <= wdata[C_SEL +: SEL_W];
         end
         if (mask_wr)
            mask <= wdata[MASK_W-1:0];
      end
   end

endmodule

// File: rtl/spdif_rxc_seq.sv
module spdif_rxc_seq
   import spdif_rxc_pkg::*;
(
   input  logic       clk,
   input  logic       rst,
   input  en_mode_e   mode,
   input  logic       wait_act,
   input  logic [1:0] retry_code,
   input  logic       stopped,
   input  logic       act_stb,
   input  logic       syncd_stb,
   input  logic       serr_stb,
   output logic       armed,
   output logic       serr_hit
);

   logic             active;
   logic             seen_q;
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] limit;

   assign active   = (mode == EN_SYNC) || (mode == EN_RECV);
   assign limit    = retry_limit(retry_code);
   assign armed    = active && (!wait_act || seen_q) && !stopped;
   assign serr_hit = armed && serr_stb && (cnt_q == limit);

   always_ff @(posedge clk) begin
      if (rst) begin
         seen_q <= 1'b0;
         cnt_q  <= '0;
      end else begin
         seen_q <= active && (seen_q || act_stb);
         if (!armed || syncd_stb || serr_hit)
            cnt_q <= '0;
         else if (serr_stb)
            cnt_q <= cnt_q + 1'b1;
      end
   end

endmodule

// File: rtl/spdif_rxc_flags.sv
module spdif_rxc_flags
   import spdif_rxc_pkg::*;
#(
   parameter int DATA_W = 24,
   parameter int CW_W   = 32
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              armed,
   input  logic              recv,
   input  logic              blk_stb,
   input  logic              par_stb,
   input  logic              ovr_stb,
   input  logic              syncd_stb,
   input  logic              ferr_stb,
   input  logic              tout_stb,
   input  logic              serr_hit,
   input  logic              smp_stb,
   input  logic [DATA_W-1:0] smp_data,
   input  logic              cw_stb,
   input  logic [CW_W-1:0]   cw_data,
   input  logic              rd_data,
   input  logic              rd_cw,
   input  logic [5:2]        clr_bits,
   input  logic              dis_wr,
   output logic [NFLAG-1:0]  stat,
   output logic [DATA_W-1:0] data_q,
   output logic [CW_W-1:0]   cw_q
);

   logic [NFLAG-1:0] set_v, clr_v;
   logic             take_smp;

   assign take_smp = armed && recv && smp_stb;

   always_comb begin
      set_v          = '0;
      set_v[F_DRDY]  = take_smp;
      set_v[F_CRDY]  = armed && cw_stb;
      set_v[F_PAR]   = armed && par_stb;
      set_v[F_OVR]   = armed && (ovr_stb || (take_smp && stat[F_DRDY] && !rd_data));
      set_v[F_BLK]   = armed && blk_stb;
      set_v[F_SYNC]  = armed && syncd_stb;
      set_v[F_FERR]  = armed && ferr_stb;
      set_v[F_SERR]  = serr_hit;
      set_v[F_TOUT]  = armed && tout_stb;
      clr_v          = '0;
      clr_v[F_DRDY]  = rd_data;
      clr_v[F_CRDY]  = rd_cw;
      clr_v[5:2]     = clr_bits;
   end

   for (genvar g = 0; g < NFLAG; g++) begin : g_flag
      if (g >= F_FATAL_LO) begin : g_fatal
         always_ff @(posedge clk) begin
            if (rst || dis_wr) stat[g] <= 1'b0;
            else               stat[g] <= stat[g] | set_v[g];
         end
      end else begin : g_event
         always_ff @(posedge clk) begin
            if (rst) stat[g] <= 1'b0;
            else     stat[g] <= (stat[g] & ~clr_v[g]) | set_v[g];
         end
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         data_q <= '0;
         cw_q   <= '0;
      end else begin
         if (take_smp)             data_q <= smp_data;
         if (set_v[F_CRDY])        cw_q   <= cw_data;
      end
   end

endmodule

// File: rtl/spdif_rx_ctl.sv
module spdif_rx_ctl
   import spdif_rxc_pkg::*;
#(
   parameter int DATA_W = 24,
   parameter int CW_W   = 32,
   parameter int SEL_W  = 3
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [2:0]        addr,
   input  logic [31:0]       wdata,
   output logic [31:0]       rdata,
   input  logic              act_stb,
   input  logic              syncd_stb,
   input  logic              blk_stb,
   input  logic              par_stb,
   input  logic              ovr_stb,
   input  logic              ferr_stb,
   input  logic              serr_stb,
   input  logic              tout_stb,
   input  logic              smp_stb,
   input  logic [DATA_W-1:0] smp_data,
   input  logic              cw_stb,
   input  logic [CW_W-1:0]   cw_data,
   output logic              sync_run,
   output logic              rx_run,
   output logic              stopped,
   output logic [SEL_W-1:0]  in_sel,
   output logic              irq
);

   if (DATA_W < 1 || DATA_W > BUS_W) begin : g_bad_data_w
      $error("DATA_W must lie in 1..BUS_W");
   end
   if (CW_W < 1 || CW_W > BUS_W) begin : g_bad_cw_w
      $error("CW_W must lie in 1..BUS_W");
   end
   if (SEL_W < 1 || C_SEL + SEL_W > BUS_W) begin : g_bad_sel_w
      $error("SEL_W does not fit the control word");
   end

   en_mode_e          mode;
   logic              wait_act, dis_wr, armed, serr_hit;
   logic [1:0]        retry_code;
   logic [MASK_W-1:0] mask;
   logic [NFLAG-1:0]  stat_w, irq_en;
   logic [DATA_W-1:0] data_q;
   logic [CW_W-1:0]   cw_q;
   logic [5:2]        clr_bits;
   logic [BUS_W-1:0]  ctrl_rb;

   spdif_rxc_regs #(.SEL_W(SEL_W)) u_regs (
      .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
      .mode(mode), .wait_act(wait_act), .retry_code(retry_code),
      .in_sel(in_sel), .mask(mask), .dis_wr(dis_wr)
   );

   spdif_rxc_seq u_seq (
      .clk(clk), .rst(rst), .mode(mode), .wait_act(wait_act),
      .retry_code(retry_code), .stopped(stopped), .act_stb(act_stb),
      .syncd_stb(syncd_stb), .serr_stb(serr_stb),
      .armed(armed), .serr_hit(serr_hit)
   );

   assign clr_bits = (wr_en && addr == A_CLR) ? wdata[5:2] : 4'b0000;

   spdif_rxc_flags #(.DATA_W(DATA_W), .CW_W(CW_W)) u_flags (
      .clk(clk), .rst(rst), .armed(armed), .recv(mode == EN_RECV),
      .blk_stb(blk_stb), .par_stb(par_stb), .ovr_stb(ovr_stb),
      .syncd_stb(syncd_stb), .ferr_stb(ferr_stb), .tout_stb(tout_stb),
      .serr_hit(serr_hit), .smp_stb(smp_stb), .smp_data(smp_data),
      .cw_stb(cw_stb), .cw_data(cw_data),
      .rd_data(rd_en && addr == A_DATA), .rd_cw(rd_en && addr == A_CWORD),
      .clr_bits(clr_bits), .dis_wr(dis_wr),
      .stat(stat_w), .data_q(data_q), .cw_q(cw_q)
   );

   assign stopped  = |stat_w[NFLAG-1:F_FATAL_LO];
   assign sync_run = armed;
   assign rx_run   = armed && (mode == EN_RECV);

   // mask bit 6 covers the whole fatal group
   for (genvar g = 0; g < NFLAG; g++) begin : g_irq_en
      assign irq_en[g] = mask[(g < F_FATAL_LO) ? g : F_FATAL_LO];
   end
   assign irq = |(stat_w & irq_en);

   always_comb begin
      ctrl_rb                  = '0;
      ctrl_rb[1:0]             = mode;
      ctrl_rb[C_WAIT]          = wait_act;
      ctrl_rb[C_RETRY +: 2]    = retry_code;
      ctrl_rb[C_SEL +: SEL_W]  = in_sel;
   end

   always_comb begin
      case (addr)
         A_CTRL:  rdata = ctrl_rb;
         A_MASK:  rdata = BUS_W'(mask);
         A_STAT:  rdata = BUS_W'(stat_w);
         A_DATA:  rdata = BUS_W'(data_q);
         A_CWORD: rdata = BUS_W'(cw_q);
         default: rdata = '0;
      endcase
   end

endmodule

// File: rtl/spdif_rx_ctl_chk.sv
module spdif_rx_ctl_chk (
   input logic       clk,
   input logic       rst,
   input logic       wr_en,
   input logic       rd_en,
   input logic [2:0] addr,
   input logic [1:0] wd_en,
   input logic       wd_b5,
   input logic       smp_stb,
   input logic       syncd_stb,
   input logic [1:0] mode_bits,
   input logic [8:0] stat,
   input logic       sync_run,
   input logic       rx_run,
   input logic       stopped,
   input logic       irq
);

   logic dis_w;
   assign dis_w = wr_en && (addr == 3'd0) && (wd_en == 2'b00);

   p_irq_source_r8: assert property (@(posedge clk) disable iff (rst)
      irq |-> (stat != 9'd0));

   p_stop_halts_r7: assert property (@(posedge clk) disable iff (rst)
      stopped |-> (!sync_run && !rx_run));

   p_err_sticky_r7: assert property (@(posedge clk) disable iff (rst)
      (stopped && !dis_w) |=> stopped);

   p_disable_clears_r7: assert property (@(posedge clk) disable iff (rst)
      dis_w |=> !stopped);

   p_rx_full_only_r2: assert property (@(posedge clk) disable iff (rst)
      rx_run |-> (mode_bits == 2'b11));

   p_drdy_read_r9: assert property (@(posedge clk) disable iff (rst)
      (rd_en && addr == 3'd4 && !smp_stb) |=> !stat[0]);

   p_clear_syncd_r6: assert property (@(posedge clk) disable iff (rst)
      (wr_en && addr == 3'd3 && wd_b5 && !syncd_stb) |=> !stat[5]);

   p_idle_no_set_r4: assert property (@(posedge clk) disable iff (rst)
      !sync_run |=> ((stat & ~$past(stat)) == 9'd0));

endmodule

bind spdif_rx_ctl spdif_rx_ctl_chk u_chk (
   .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
   .wd_en(wdata[1:0]), .wd_b5(wdata[5]), .smp_stb(smp_stb),
   .syncd_stb(syncd_stb), .mode_bits(mode), .stat(stat_w),
   .sync_run(sync_run), .rx_run(rx_run), .stopped(stopped), .irq(irq)
);

// File: tb/tb_spdif_rx_ctl.sv
module tb_spdif_rx_ctl;
   localparam int DW = 24;
   localparam int CW = 32;
   localparam int SW = 3;

   logic clk = 1'b0;
   logic rst = 1'b1;
   always #5 clk = ~clk;

   logic wr_en = 0, rd_en = 0;
   logic [2:0] addr = 0;
   logic [31:0] wdata = 0, rdata;
   logic act_stb = 0, syncd_stb = 0, blk_stb = 0, par_stb = 0, ovr_stb = 0;
   logic ferr_stb = 0, serr_stb = 0, tout_stb = 0, smp_stb = 0, cw_stb = 0;
   logic [DW-1:0] smp_data = 0;
   logic [CW-1:0] cw_data = 0;
   logic sync_run, rx_run, stopped, irq;
   logic [SW-1:0] in_sel;

   spdif_rx_ctl #(.DATA_W(DW), .CW_W(CW), .SEL_W(SW)) dut (
      .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
      .wdata(wdata), .rdata(rdata), .act_stb(act_stb), .syncd_stb(syncd_stb),
      .blk_stb(blk_stb), .par_stb(par_stb), .ovr_stb(ovr_stb),
      .ferr_stb(ferr_stb), .serr_stb(serr_stb), .tout_stb(tout_stb),
      .smp_stb(smp_stb), .smp_data(smp_data), .cw_stb(cw_stb),
      .cw_data(cw_data), .sync_run(sync_run), .rx_run(rx_run),
      .stopped(stopped), .in_sel(in_sel), .irq(irq)
   );

   int n_chk = 0, n_err = 0;

   // ---------------- behavioural reference model ----------------
   logic [1:0]  m_en = 0, m_retry = 0;
   logic        m_wait = 0, m_seen = 0;
   logic [2:0]  m_sel = 0;
   logic [6:0]  m_mask = 0;
   logic [8:0]  m_stat = 0;
   logic [31:0] m_data = 0, m_cw = 0;
   int          m_cnt = 0;
   logic [8:0]  s_set, s_clr, s_next;
   bit          arm, recv, hit, dis, nseen;
   int          ncnt;

   function automatic bit m_active();
      return (m_en == 2'b01) || (m_en == 2'b11);
   endfunction
   function automatic bit m_armed();
      return m_active() && (!m_wait || m_seen) && (m_stat[8:6] == 3'b000);
   endfunction
   function automatic int m_lim();
      case (m_retry)
         2'd0: return 0;
         2'd1: return 3;
         2'd2: return 15;
         default: return 63;
      endcase
   endfunction
   function automatic bit m_irq();
      logic [8:0] e;
      e = {m_mask[6], m_mask[6], m_mask};
      return |(m_stat & e);
   endfunction
   function automatic logic [31:0] m_read(logic [2:0] a);
      case (a)
         3'd0: return {13'b0, m_sel, 10'b0, m_retry, 1'b0, m_wait, m_en};
         3'd1: return {25'b0, m_mask};
         3'd2: return {23'b0, m_stat};
         3'd4: return m_data;
         3'd5: return m_cw;
         default: return 32'b0;
      endcase
   endfunction

   always @(posedge clk) begin
      if (rst) begin
         m_en = 0; m_retry = 0; m_wait = 0; m_seen = 0; m_sel = 0;
         m_mask = 0; m_stat = 0; m_data = 0; m_cw = 0; m_cnt = 0;
      end else begin
         arm  = m_armed();
         recv = (m_en == 2'b11);
         hit  = arm && serr_stb && (m_cnt == m_lim());
         s_set = '0;
         s_set[0] = arm && recv && smp_stb;
         s_set[1] = arm && cw_stb;
         s_set[2] = arm && par_stb;
         s_set[3] = arm && (ovr_stb || (recv && smp_stb && m_stat[0] && !(rd_en && addr == 3'd4)));
         s_set[4] = arm && blk_stb;
         s_set[5] = arm && syncd_stb;
         s_set[6] = arm && ferr_stb;
         s_set[7] = hit;
         s_set[8] = arm && tout_stb;
         s_clr = '0;
         if (rd_en && addr == 3'd4) s_clr[0] = 1'b1;
         if (rd_en && addr == 3'd5) s_clr[1] = 1'b1;
         if (wr_en && addr == 3'd3) s_clr[5:2] = wdata[5:2];
         dis = wr_en && addr == 3'd0 && wdata[1:0] == 2'b00;
         s_next = (m_stat & ~s_clr) | s_set;
         if (dis) s_next[8:6] = 3'b000;
         if (!arm || syncd_stb || hit) ncnt = 0;
         else if (serr_stb)            ncnt = m_cnt + 1;
         else                          ncnt = m_cnt;
         nseen = m_active() && (m_seen || act_stb);
         if (s_set[0]) m_data = 32'(smp_data);
         if (s_set[1]) m_cw   = 32'(cw_data);
         m_stat = s_next;
         m_cnt  = ncnt;
         m_seen = nseen;
         if (wr_en && addr == 3'd0) begin
            m_en = wdata[1:0]; m_wait = wdata[2];
            m_retry = wdata[5:4]; m_sel = wdata[18:16];
         end
         if (wr_en && addr == 3'd1) m_mask = wdata[6:0];
      end
   end

   // ---------------- checking helpers ----------------
   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic compare_all();
      chk("R8 irq vs model", 32'(irq), 32'(m_irq()));
      chk("R7 stopped vs model", 32'(stopped), 32'(m_stat[8:6] != 0));
      chk("R3 sync_run vs model", 32'(sync_run), 32'(m_armed()));
      chk("R2 rx_run vs model", 32'(rx_run), 32'(m_armed() && m_en == 2'b11));
      chk("R11 in_sel vs model", 32'(in_sel), 32'(m_sel));
      chk("R4 rdata vs model", rdata, m_read(addr));
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
      compare_all();
      wr_en = 0; rd_en = 0;
      act_stb = 0; syncd_stb = 0; blk_stb = 0; par_stb = 0; ovr_stb = 0;
      ferr_stb = 0; serr_stb = 0; tout_stb = 0; smp_stb = 0; cw_stb = 0;
   endtask

   task automatic wr(logic [2:0] a, logic [31:0] d);
      wr_en = 1; addr = a; wdata = d; tick();
   endtask
   task automatic rd(logic [2:0] a);
      rd_en = 1; addr = a; tick();
   endtask
   task automatic peek(logic [2:0] a, logic [31:0] exp, string tag);
      addr = a; #1; chk(tag, rdata, exp);
   endtask

   initial begin
      #1_500_000;
      n_err++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst = 0;
      tick();
      // R1 reset state
      peek(0, 32'h0, "R1 control after reset");
      peek(2, 32'h0, "R1 status after reset");
      chk("R1 irq after reset", 32'(irq), 0);
      chk("R1 run outputs after reset", 32'({sync_run, rx_run, stopped}), 0);

      // R2/R11: sync-only mode, retry code 1, input 5
      wr(0, 32'h0005_0011);
      peek(0, 32'h0005_0011, "R11 control readback");
      chk("R11 in_sel", 32'(in_sel), 5);
      chk("R2 sync-only", 32'({sync_run, rx_run}), 32'b10);

      // R5: three tolerated sync errors, fourth reported
      repeat (3) begin serr_stb = 1; tick(); end
      peek(2, 32'h0, "R5 tolerated retries");
      serr_stb = 1; tick();
      peek(2, 32'h80, "R5 retry budget exhausted");
      chk("R7 stopped after sync error", 32'(stopped), 1);
      chk("R7 sync halted", 32'(sync_run), 0);

      // R7: clear register cannot clear fatal flags; R8 group mask
      wr(3, 32'h1C0);
      peek(2, 32'h80, "R7 clear register ignores fatal bits");
      wr(1, 32'h40);
      chk("R8 irq from fatal group", 32'(irq), 1);
      wr(0, 32'h0005_0010);
      peek(2, 32'h0, "R7 disable clears fatal bits");
      chk("R8 irq drops", 32'(irq), 0);

      // R3: wait for activity under full reception
      wr(0, 32'h7);
      chk("R3 waits for activity", 32'(sync_run), 0);
      syncd_stb = 1; tick();
      peek(2, 32'h0, "R3 strobe ignored before activity");
      act_stb = 1; tick();
      chk("R3 armed after activity", 32'(sync_run), 1);
      chk("R2 full reception", 32'(rx_run), 1);
      syncd_stb = 1; tick();
      peek(2, 32'h20, "R4 sync done at bit 5");
      wr(1, 32'h20);
      chk("R8 irq from sync done", 32'(irq), 1);
      wr(3, 32'h20);
      peek(2, 32'h0, "R6 write-one clears sync done");
      chk("R8 irq cleared", 32'(irq), 0);

      // R9: samples, overrun, read clear
      smp_data = 24'h0ABCDE; smp_stb = 1; tick();
      peek(2, 32'h1, "R9 data ready");
      peek(4, 32'h000A_BCDE, "R9 data word");
      smp_data = 24'h000123; smp_stb = 1; tick();
      peek(2, 32'h9, "R9 overrun on unread sample");
      peek(4, 32'h123, "R9 newer sample kept");
      wr(3, 32'h3);
      peek(2, 32'h9, "R6 bits 1:0 not write-one-clear");
      rd(4);
      peek(2, 32'h8, "R9 read clears data ready");
      wr(3, 32'h8);
      peek(2, 32'h0, "R6 overrun cleared");

      // R10: control word
      cw_data = 32'hDEAD_BEEF; cw_stb = 1; tick();
      peek(2, 32'h2, "R10 control word ready");
      peek(5, 32'hDEAD_BEEF, "R10 control word");
      rd(5);
      peek(2, 32'h0, "R10 read clears ready");

      // R4: block + parity; R2 reserved code
      blk_stb = 1; par_stb = 1; tick();
      peek(2, 32'h14, "R4 block start and parity bits");
      wr(0, 32'h6);
      chk("R2 code 10 idles", 32'({sync_run, rx_run}), 0);
      peek(2, 32'h14, "R2 event flags kept across mode change");
      par_stb = 1; ovr_stb = 1; tick();
      peek(2, 32'h14, "R4 strobes ignored while idle");
      wr(3, 32'h14);
      wr(0, 32'h7);
      chk("R3 activity memory lost when idle", 32'(sync_run), 0);

      // R9: no samples in sync-only; R10 control words still taken
      wr(0, 32'h1);
      smp_stb = 1; tick();
      peek(2, 32'h0, "R9 no sample in sync-only mode");
      cw_stb = 1; cw_data = 32'h1234_5678; tick();
      peek(2, 32'h2, "R10 control word in sync-only mode");
      rd(5);

      // R6: set wins over clear in same cycle
      wr_en = 1; addr = 3; wdata = 32'h20; syncd_stb = 1; tick();
      peek(2, 32'h20, "R6 set wins over clear");
      wr(3, 32'h20);

      // R5: code 0 reports at once
      serr_stb = 1; tick();
      peek(2, 32'h80, "R5 code 0 reports first sync error");
      wr(0, 32'h0);
      // R5: code 3 tolerates 63
      wr(0, 32'h31);
      repeat (63) begin serr_stb = 1; tick(); end
      peek(2, 32'h0, "R5 code 3 tolerates 63");
      serr_stb = 1; tick();
      peek(2, 32'h80, "R5 code 3 reports 64th");
      wr(0, 32'h0);

      // R7: timeout and frame error
      wr(0, 32'h1);
      tout_stb = 1; tick();
      peek(2, 32'h100, "R7 timeout is fatal");
      ferr_stb = 1; tick();
      peek(2, 32'h100, "R7 stopped receiver ignores strobes");
      wr(0, 32'h0);
      wr(0, 32'h1);
      ferr_stb = 1; tick();
      peek(2, 32'h40, "R7 frame error is fatal");
      wr(0, 32'h0);

      // mixed traffic against the model
      for (int i = 0; i < 600; i++) begin
         int r;
         r = $urandom_range(0, 15);
         if (r == 0) begin
            wr_en = 1; addr = 3'd0; wdata = $urandom;
            if ($urandom_range(0, 3) != 0) wdata[1:0] = 2'b11;
         end else if (r == 1) begin
            wr_en = 1; addr = 3'd1; wdata = $urandom;
         end else if (r < 4) begin
            wr_en = 1; addr = 3'd3; wdata = $urandom;
         end else if (r < 8) begin
            rd_en = 1; addr = 3'($urandom_range(0, 7));
         end else begin
            addr = 3'($urandom_range(0, 7));
         end
         act_stb   = ($urandom_range(0, 3) == 0);
         syncd_stb = ($urandom_range(0, 7) == 0);
         blk_stb   = ($urandom_range(0, 7) == 0);
         par_stb   = ($urandom_range(0, 15) == 0);
         ovr_stb   = ($urandom_range(0, 15) == 0);
         ferr_stb  = ($urandom_range(0, 63) == 0);
         serr_stb  = ($urandom_range(0, 7) == 0);
         tout_stb  = ($urandom_range(0, 63) == 0);
         smp_stb   = ($urandom_range(0, 2) == 0);
         cw_stb    = ($urandom_range(0, 3) == 0);
         smp_data  = DW'($urandom);
         cw_data   = $urandom;
         tick();
      end

      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

endmodule